// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This peripheral holds three reloadable down-counting channels and one 40-bit free-running up-counter behind a single word-addressed register bus. Two channels are 16 bits wide and the third is 32 bits wide. Each channel counts on one of two tick enables, the fast one or the slow one, and its control register picks which. When a channel counts past zero it raises its interrupt line. It then either reloads from its load register (periodic mode) or wraps to all ones (free-running mode). The interrupt stays high until software writes any value to that channel's clear register.

The 40-bit counter counts up on its own tick enable while enabled and never interrupts. Its enable bit sits in its high-word register. To program a channel, software writes zero to its control register, writes the load register, and then writes the control register again with the enable bit set. A write to the load register also copies the value into the live count at once. Bus reads are combinational, so the read data follows the address in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero and all three interrupt lines are low.
- R2: A write to a channel's load register (offset +0x0) sets both the load value and the live count (read at +0x4) by the next cycle, truncated to the channel's width (channels at bases 0x00 and 0x20 keep 16 bits; the channel at 0x80 keeps 32 bits).
- R3: With the enable bit (bit 7 of the control register at +0x8) set, each selected tick lowers the count by one. With the enable bit clear, ticks leave the count unchanged.
- R4: Control bit 3 selects the fast tick when set and the slow tick when clear. The tick that is not selected has no effect on the count.
- R5: In periodic mode (control bit 6 set), a selected tick at count zero reloads the load value and sets the channel's interrupt, so a load of N gives an interrupt every N+1 ticks.
- R6: In free-running mode (control bit 6 clear), a selected tick at count zero wraps the count to all ones for the channel's width and sets the interrupt.
- R7: An interrupt stays high until a write of any data to that channel's clear register (+0xC). A clear write to another channel leaves it high.
- R8: When an underflow and a clear write to the same channel fall in one cycle, the interrupt stays set.
- R9: A write of zero to the control register stops the channel and holds its count. The control register reads back bits 7, 6 and 3 as written.
- R10: The 40-bit counter adds one on each free tick while bit 8 of the register at 0x64 is set, and holds otherwise. It reads bits 31:0 at 0x60, and at 0x64 it reads bits 39:32 in bits 7:0 with the enable in bit 8.
- R11: Reads of unmapped offsets return zero. Writes to a value register or to 0x60 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_fast | input | 1 | Fast-rate count enable for the channels |
| tick_slow | input | 1 | Slow-rate count enable for the channels |
| tick_free | input | 1 | Count enable for the 40-bit counter |
| irq | output | 3 | Interrupt level per channel, bit 0 for base 0x00 |

## Verification
Read data depends only on the address and the stored state. It is valid in the same cycle the address is applied. A write, or a tick applied in cycle N, updates the count, the control or the interrupt at the clock edge that ends cycle N. The result is therefore visible from the following cycle onward. The driver applies every stimulus just after a falling edge and holds it for one full cycle. Each expected read or interrupt value is queued in the cycle where it becomes valid. The monitor compares it 2 ns after that same falling edge, well away from the rising edge where state changes.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the interval timer.
// Assumes byte addressing with word-aligned registers.
package tmr_pkg;

    localparam int BUS_AW       = 8;
    localparam int BUS_DW       = 32;
    localparam int NUM_CH       = 3;

    // Control register bit positions
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_FAST_BIT = 3;

    // Register selector within a channel window (address bits 3:2)
    localparam logic [1:0] SEL_LOAD  = 2'd0;
    localparam logic [1:0] SEL_VALUE = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_CLEAR = 2'd3;

    // 40-bit counter register addresses
    localparam logic [BUS_AW-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [BUS_AW-1:0] FREE_HI_ADDR = 8'h64;
    localparam int                FREE_EN_BIT  = 8;

    typedef struct packed {
        logic en;
        logic periodic;
        logic fast;
    } chan_ctrl_t;

    // Base address of channel idx
    function automatic logic [BUS_AW-1:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/tmr_chan.sv
// One reloadable down-counting channel of width W.
// Assumes: the tick inputs are single-cycle enables, and a load write
// takes priority over a tick in the same cycle. An underflow beats a
// clear write in the same cycle.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             load_we,
    input  logic [W-1:0]     load_d,
    input  logic             ctrl_we,
    input  chan_ctrl_t       ctrl_d,
    input  logic             clr_we,
    output logic [W-1:0]     load_q,
    output logic [W-1:0]     value_q,
    output chan_ctrl_t       ctrl_q,
    output logic             irq
);

    logic sel_tick;
    logic step;
    logic uflow;

    // Pick the tick rate and decide whether this cycle counts
    always_comb begin
        sel_tick = ctrl_q.fast ? tick_fast : tick_slow;
        step     = ctrl_q.en && sel_tick && !load_we;
        uflow    = step && (value_q == '0);
    end

    // Load register
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (load_we) load_q <= load_d;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_d;
    end

    // Live count: load copy, decrement, reload or wrap
    always_ff @(posedge clk) begin
        if (!rst_n)            value_q <= '0;
        else if (load_we)      value_q <= load_d;
        else if (uflow)        value_q <= ctrl_q.periodic ? load_q : '1;
        else if (step)         value_q <= value_q - W'(1);
    end

    // Interrupt level: set on underflow, cleared by a clear write
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (uflow)  irq <= 1'b1;
        else if (clr_we) irq <= 1'b0;
    end

    a_r8_uflow_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && clr_we) |=> irq);

    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_we) |=> irq);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && ctrl_q.periodic) |=> (value_q == $past(load_q)));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !ctrl_q.periodic) |=> (value_q == {W{1'b1}}));

    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !load_we) |=> $stable(value_q));

    a_r4_unselected_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && !load_we && !(ctrl_q.fast ? tick_fast : tick_slow)) |=> $stable(value_q));

endmodule

// File: rtl/tmr_free.sv
// Free-running up-counter of width W with a software enable.
// Assumes W is between 33 and 40 so the high part fits one byte.
// It never interrupts and wraps silently.
module tmr_free #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en_we,
    input  logic         en_d,
    output logic [W-1:0] count,
    output logic         en_q
);

    // Enable bit, written through the high-word register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_we) en_q <= en_d;
    end

    // Count up once per tick while enabled
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (en_q && tick) count <= count + W'(1);
    end

    a_r10_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick) |=> (count == $past(count) + W'(1)));

    a_r10_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_q && tick) |=> $stable(count));

endmodule

// File: rtl/interval_timer.sv
// Interval timer top: address decode, three channels of mixed width,
// a free-running counter, and the combinational read mux.
// Assumes one bus write per cycle strobe and word-aligned addresses.
// Misaligned or unmapped addresses read zero.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              tick_free,
    output logic [NUM_CH-1:0] irq
);

    localparam int HI_W = FREE_W - 32;

    logic [NUM_CH-1:0] chan_hit;
    logic [1:0]        reg_sel;
    logic              free_lo_hit;
    logic              free_hi_hit;
    logic              mapped;
    chan_ctrl_t        ctrl_wd;

    logic [BUS_DW-1:0] ld_ext  [NUM_CH];
    logic [BUS_DW-1:0] val_ext [NUM_CH];
    chan_ctrl_t        ctl_q   [NUM_CH];

    logic [FREE_W-1:0] free_cnt;
    logic              free_en;

    // Address decode shared by reads and writes
    always_comb begin
        reg_sel     = bus_addr[3:2];
        free_lo_hit = (bus_addr == FREE_LO_ADDR);
        free_hi_hit = (bus_addr == FREE_HI_ADDR);
        for (int i = 0; i < NUM_CH; i++) begin
            chan_hit[i] = (bus_addr[7:4] == chan_base(i)[7:4]) && (bus_addr[1:0] == 2'b00);
        end
        ctrl_wd.en       = bus_wdata[CTL_EN_BIT];
        ctrl_wd.periodic = bus_wdata[CTL_PER_BIT];
        ctrl_wd.fast     = bus_wdata[CTL_FAST_BIT];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam int CW = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
        logic [CW-1:0] ld_w;
        logic [CW-1:0] val_w;

        tmr_chan #(.W(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .load_we   (bus_wr && chan_hit[g] && (reg_sel == SEL_LOAD)),
            .load_d    (bus_wdata[CW-1:0]),
            .ctrl_we   (bus_wr && chan_hit[g] && (reg_sel == SEL_CTRL)),
            .ctrl_d    (ctrl_wd),
            .clr_we    (bus_wr && chan_hit[g] && (reg_sel == SEL_CLEAR)),
            .load_q    (ld_w),
            .value_q   (val_w),
            .ctrl_q    (ctl_q[g]),
            .irq       (irq[g])
        );

        assign ld_ext[g]  = BUS_DW'(ld_w);
        assign val_ext[g] = BUS_DW'(val_w);
    end

    tmr_free #(.W(FREE_W)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_free),
        .en_we (bus_wr && free_hi_hit),
        .en_d  (bus_wdata[FREE_EN_BIT]),
        .count (free_cnt),
        .en_q  (free_en)
    );

    // Read mux: one source per mapped address, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        mapped    = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_hit[i]) begin
                mapped = 1'b1;
                case (reg_sel)
                    SEL_LOAD:  bus_rdata = ld_ext[i];
                    SEL_VALUE: bus_rdata = val_ext[i];
                    SEL_CTRL: begin
                        bus_rdata[CTL_EN_BIT]   = ctl_q[i].en;
                        bus_rdata[CTL_PER_BIT]  = ctl_q[i].periodic;
                        bus_rdata[CTL_FAST_BIT] = ctl_q[i].fast;
                    end
                    default:   bus_rdata = '0;
                endcase
            end
        end
        if (free_lo_hit) begin
            mapped    = 1'b1;
            bus_rdata = free_cnt[31:0];
        end
        if (free_hi_hit) begin
            mapped                 = 1'b1;
            bus_rdata[HI_W-1:0]    = free_cnt[FREE_W-1:32];
            bus_rdata[FREE_EN_BIT] = free_en;
        end
    end

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

    a_r1_no_irq_after_reset: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));

endmodule

// File: tb/interval_timer_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor
// compares them 2 ns after the falling edge where they are due.
module interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_free = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;

    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    interval_timer u_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .tick_free (tick_free),
        .irq       (irq)
    );

    // Monitor: pop one expected item per cycle and compare
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (kind_q.size() > 0) begin
                bit          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = k ? {29'd0, irq} : bus_rdata;
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual 0x%08h expected 0x%08h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic f = 0, input logic s = 0, input logic r = 0);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick_fast = f;
        tick_slow = s;
        tick_free = r;
        @(negedge clk);
        bus_wr    = 1'b0;
        tick_fast = 1'b0;
        tick_slow = 1'b0;
        tick_free = 1'b0;
    endtask

    task automatic ticks(input int n, input logic f, input logic s, input logic r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_fast = f;
            tick_slow = s;
            tick_free = r;
            @(negedge clk);
            tick_fast = 1'b0;
            tick_slow = 1'b0;
            tick_free = 1'b0;
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        kind_q.push_back(1'b0);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic irq_chk(input logic [2:0] e, input string t);
        @(negedge clk);
        kind_q.push_back(1'b1);
        exp_q.push_back({29'd0, e});
        tag_q.push_back(t);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(8'h00, 32'h0, "R1 load");
        rd_chk(8'h04, 32'h0, "R1 value");
        rd_chk(8'h88, 32'h0, "R1 ctrl");
        rd_chk(8'h60, 32'h0, "R1 free lo");
        rd_chk(8'h64, 32'h0, "R1 free hi");
        irq_chk(3'b000, "R1 irq");

        // R2: load write sets load and value, truncated to 16 bits
        wr(8'h00, 32'h0001_2345);
        rd_chk(8'h00, 32'h2345, "R2 load trunc");
        rd_chk(8'h04, 32'h2345, "R2 value copy");

        // R11: value writes ignored, unmapped reads zero
        wr(8'h04, 32'h1111);
        rd_chk(8'h04, 32'h2345, "R11 value write ignored");
        rd_chk(8'h50, 32'h0, "R11 unmapped");
        rd_chk(8'h02, 32'h0, "R11 misaligned");

        // R3/R4: slow tick counts, fast tick ignored
        wr(8'h08, 32'h80);
        rd_chk(8'h08, 32'h80, "R9 ctrl readback");
        ticks(3, 1'b0, 1'b1, 1'b0);
        rd_chk(8'h04, 32'h2342, "R3 count down");
        ticks(2, 1'b1, 1'b0, 1'b0);
        rd_chk(8'h04, 32'h2342, "R4 fast ignored");

        // R4: fast select
        wr(8'h08, 32'h88);
        ticks(2, 1'b1, 1'b0, 1'b0);
        rd_chk(8'h04, 32'h2340, "R4 fast counts");
        ticks(1, 1'b0, 1'b1, 1'b0);
        rd_chk(8'h04, 32'h2340, "R4 slow ignored");

        // R9: stop holds count
        wr(8'h08, 32'h0);
        ticks(1, 1'b1, 1'b1, 1'b0);
        rd_chk(8'h04, 32'h2340, "R9 stopped");
        rd_chk(8'h08, 32'h0, "R9 ctrl zero");

        // R5: periodic reload on channel at 0x20
        wr(8'h20, 32'd2);
        wr(8'h28, 32'hC8);
        ticks(2, 1'b1, 1'b0, 1'b0);
        rd_chk(8'h24, 32'd0, "R5 at zero");
        irq_chk(3'b000, "R5 no irq yet");
        ticks(1, 1'b1, 1'b0, 1'b0);
        rd_chk(8'h24, 32'd2, "R5 reload");
        irq_chk(3'b010, "R5 irq set");

        // R7: level held, other clear ignored, own clear works
        ticks(1, 1'b1, 1'b0, 1'b0);
        irq_chk(3'b010, "R7 held");
        wr(8'h0C, 32'h1);
        irq_chk(3'b010, "R7 other clear");
        wr(8'h2C, 32'hDEAD);
        irq_chk(3'b000, "R7 cleared");
        wr(8'h28, 32'h0);

        // R6: free-running wrap on 32-bit and 16-bit channels
        wr(8'h80, 32'd1);
        wr(8'h88, 32'h88);
        ticks(2, 1'b1, 1'b0, 1'b0);
        rd_chk(8'h84, 32'hFFFF_FFFF, "R6 wrap 32");
        irq_chk(3'b100, "R6 irq 32");
        wr(8'h00, 32'd0);
        wr(8'h08, 32'h80);
        ticks(1, 1'b0, 1'b1, 1'b0);
        rd_chk(8'h04, 32'h0000_FFFF, "R6 wrap 16");
        irq_chk(3'b101, "R6 irq 16");
        wr(8'h0C, 32'h0);
        wr(8'h8C, 32'h0);
        irq_chk(3'b000, "R7 both cleared");
        wr(8'h08, 32'h0);
        wr(8'h88, 32'h0);

        // R8: underflow and clear in one cycle
        wr(8'h20, 32'd0);
        wr(8'h28, 32'hC8);
        wr(8'h2C, 32'h5, 1'b1, 1'b0, 1'b0);
        irq_chk(3'b010, "R8 underflow wins");
        wr(8'h2C, 32'h5);
        irq_chk(3'b000, "R8 later clear");
        wr(8'h28, 32'h0);

        // R10: free counter enable, count, hold
        ticks(2, 1'b0, 1'b0, 1'b1);
        rd_chk(8'h60, 32'h0, "R10 disabled");
        wr(8'h64, 32'h100);
        ticks(3, 1'b0, 1'b0, 1'b1);
        rd_chk(8'h60, 32'd3, "R10 counts");
        rd_chk(8'h64, 32'h100, "R10 hi word");
        wr(8'h60, 32'h55);
        rd_chk(8'h60, 32'd3, "R11 free lo write ignored");
        wr(8'h64, 32'h0);
        ticks(1, 1'b0, 1'b0, 1'b1);
        rd_chk(8'h60, 32'd3, "R10 holds");
        rd_chk(8'h64, 32'h0, "R10 enable off");

        repeat (4) @(negedge clk);
        if (kind_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard %0d items left, expected 0", kind_q.size());
        end
        summary();
        $finish;
    end

endmodule